// File: doc/BRIEF.md
# Cascadable LCD Segment Driver Logic

This block is the digital core of a 40-output dot-matrix LCD segment driver. Display bits arrive serially on two data inputs. Each input feeds its own 20-stage shift register, and both registers advance on the falling edge of a shift clock. Each register has a serial tap at its last stage. Tying the first tap to the second data input turns the pair into one 40-stage chain. The second tap feeds the first data input of a further driver, so several drivers can serve a wider panel.

A latch clock, sampled as a level, copies all 40 shift bits into an output latch while it is high. While it is low, the latch holds its previous contents. Every output carries a 2-bit code that names one of four drive levels. The code is chosen from that output's latched bit and an alternating-frame signal. Only the level choice is modelled; voltage switching is outside the block.

The shift clock and the latch clock are sampled in a fast system clock domain, so the whole design is synchronous to that clock.

Top module: `lcd_seg_driver`

## Requirements
- R1: A synchronous active-low reset clears both shift registers and the latch to zero. After reset both serial taps read 0, and every output shows the non-selected code (01 when the alternating signal is 0).
- R2: The shift registers advance only on a falling edge (1 then 0 in consecutive system clocks) of the shift clock. Each advance captures the data input of the register into stage 1. A rising edge or a steady shift clock leaves the contents unchanged.
- R3: Output k (k = 1..20) shows stage k of the first register, and output 20+k shows stage k of the second register. After 20 falling edges, the first bit entered sits at output 20 (first register) or output 40 (second register). Output k occupies bits [2k-1:2k-2] of segLevel.
- R4: dataOut1 presents stage 20 of the first register, so a bit appears there 20 shift edges after it entered.
- R5: dataOut2 presents stage 20 of the second register. With dataOut1 tied to dataIn2 and dataOut2 tied to the next driver's dataIn1, the drivers form one continuous chain of 40 stages per driver.
- R6: In every system clock in which the latch clock is high, the latch loads the 40 shift bits that were present before that clock. If a shift edge falls in the same clock, the latch takes the contents from before the shift.
- R7: While the latch clock is low, the latch and the outputs hold, even while shifting continues.
- R8: The level code is selected as follows: latched 1 with alternating signal 1 gives 11 (most negative, selected); latched 1 with alternating 0 gives 00 (top supply, selected); latched 0 with alternating 1 gives 10 (upper mid level, non-selected); latched 0 with alternating 0 gives 01 (lower mid level, non-selected).
- R9: Changing the alternating signal alone changes the outputs combinationally, with no re-latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| shiftClk | input | 1 | Shift clock; the registers advance on its falling edge |
| latchClk | input | 1 | Latch clock; the latch loads while it is high |
| dataIn1 | input | 1 | Serial input of the first register (outputs 1..20) |
| dataIn2 | input | 1 | Serial input of the second register (outputs 21..40) |
| altFrame | input | 1 | Alternating-frame signal |
| dataOut1 | output | 1 | Tap at stage 20 of the first register |
| dataOut2 | output | 1 | Tap at stage 20 of the second register |
| segLevel | output | 80 | Two-bit level code per output; output k in bits [2k-1:2k-2] |

## Verification
A shift edge and a high latch clock can fall in the same system clock. In that clock the latch must take the shift contents from before the edge, while the registers move on by one stage. The bench provokes this by dropping the shift clock in the same cycle that it raises the latch clock for a single cycle. It then compares the outputs of two cascaded drivers against a model latch that was copied from the model chain before the model shift was applied. Random runs also mix latch pulses, alternating-signal toggles and shift edges, and compare every output after each of them.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  typedef enum logic [1:0] {
    LVL_TOP    = 2'b00,
    LVL_MID_LO = 2'b01,
    LVL_MID_HI = 2'b10,
    LVL_BOTTOM = 2'b11
  } level_e;

  typedef struct packed {
    logic shiftEn;
    logic latchEn;
  } strobe_t;

  function automatic level_e pick_level(input logic bitVal, input logic alt);
    level_e lvl;
    case ({bitVal, alt})
      2'b11:   lvl = LVL_BOTTOM;
      2'b10:   lvl = LVL_TOP;
      2'b01:   lvl = LVL_MID_HI;
      default: lvl = LVL_MID_LO;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/lcd_seg_ctrl.sv
module lcd_seg_ctrl
  import lcd_seg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    shiftClk,
  input  logic    latchClk,
  output strobe_t strobe
);

  logic shiftClkQ;

  always_ff @(posedge clk) begin
    if (!rstN) shiftClkQ <= 1'b0;
    else       shiftClkQ <= shiftClk;
  end

  always_comb begin
    strobe.shiftEn = shiftClkQ & ~shiftClk;
    strobe.latchEn = latchClk;
  end

  // R2
  shift_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |-> ($past(shiftClk) && !shiftClk));

endmodule

// File: rtl/lcd_seg_datapath.sv
module lcd_seg_datapath
  import lcd_seg_pkg::*;
#(
  parameter int STAGES = 20
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobe,
  input  logic                        dataIn1,
  input  logic                        dataIn2,
  input  logic                        altFrame,
  output logic                        dataOut1,
  output logic                        dataOut2,
  output logic [2*STAGES*$bits(level_e)-1:0] segLevel
);

  localparam int NSEG = 2 * STAGES;
  localparam int LW   = $bits(level_e);

  logic [1:0][STAGES-1:0] chain;
  logic [1:0]             serIn;
  logic [NSEG-1:0]        latchQ;

  assign serIn = {dataIn2, dataIn1};

  for (genvar g = 0; g < 2; g++) begin : g_chain
    always_ff @(posedge clk) begin
      if (!rstN)               chain[g] <= '0;
      else if (strobe.shiftEn) chain[g] <= {chain[g][STAGES-2:0], serIn[g]};
    end
  end

  assign dataOut1 = chain[0][STAGES-1];
  assign dataOut2 = chain[1][STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN)               latchQ <= '0;
    else if (strobe.latchEn) latchQ <= {chain[1], chain[0]};
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    assign segLevel[k*LW +: LW] = pick_level(latchQ[k], altFrame);
  end

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> (chain[0][0] == $past(dataIn1)) && (chain[1][0] == $past(dataIn2)));

  // R2
  no_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(chain));

  // R4
  tap_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> dataOut1 == $past(chain[0][STAGES-2]));

  // R6
  latch_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchEn |=> latchQ == $past({chain[1], chain[0]}));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchEn |=> $stable(latchQ));

endmodule

// File: rtl/lcd_seg_driver.sv
module lcd_seg_driver
  import lcd_seg_pkg::*;
#(
  parameter int STAGES = 20,
  localparam int SEG_W = 2 * STAGES * $bits(level_e)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftClk,
  input  logic             latchClk,
  input  logic             dataIn1,
  input  logic             dataIn2,
  input  logic             altFrame,
  output logic             dataOut1,
  output logic             dataOut2,
  output logic [SEG_W-1:0] segLevel
);

  strobe_t strobe;

  lcd_seg_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .shiftClk (shiftClk),
    .latchClk (latchClk),
    .strobe   (strobe)
  );

  lcd_seg_datapath #(.STAGES(STAGES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataIn1  (dataIn1),
    .dataIn2  (dataIn2),
    .altFrame (altFrame),
    .dataOut1 (dataOut1),
    .dataOut2 (dataOut2),
    .segLevel (segLevel)
  );

endmodule

// File: tb/lcd_seg_driver_tb_top.sv
module lcd_seg_driver_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftClk = 1'b0;
  logic latchClk = 1'b0;
  logic dataIn = 1'b0;
  logic altFrame = 1'b0;
  logic tapA1, tapA2, tapB1, tapB2;
  logic [79:0] segA, segB;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [79:0] chainM = '0;
  logic [79:0] latchM = '0;

  always #4 clk = ~clk;

  lcd_seg_driver dut_i (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .latchClk(latchClk),
    .dataIn1(dataIn), .dataIn2(tapA1), .altFrame(altFrame),
    .dataOut1(tapA1), .dataOut2(tapA2), .segLevel(segA)
  );

  lcd_seg_driver dut2_i (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .latchClk(latchClk),
    .dataIn1(tapA2), .dataIn2(tapB1), .altFrame(altFrame),
    .dataOut1(tapB1), .dataOut2(tapB2), .segLevel(segB)
  );

  function automatic logic [1:0] codeOf(input logic b, input logic a);
    if (b) return a ? 2'b11 : 2'b00;
    else   return a ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [79:0] expSeg(input logic [39:0] bits, input logic a);
    logic [79:0] v;
    for (int k = 0; k < 40; k++) v[2*k +: 2] = codeOf(bits[k], a);
    return v;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkSegs(input string req);
    check(req, segA, expSeg(latchM[39:0], altFrame));
    check(req, segB, expSeg(latchM[79:40], altFrame));
  endtask

  task automatic checkTaps(input string req);
    check(req, {76'd0, tapA1, tapA2, tapB1, tapB2},
          {76'd0, chainM[19], chainM[39], chainM[59], chainM[79]});
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk); dataIn = b; shiftClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0;
    @(negedge clk); chainM = {chainM[78:0], b};
  endtask

  task automatic latchPulse();
    @(negedge clk); latchClk = 1'b1;
    @(negedge clk); latchClk = 1'b0; latchM = chainM;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkSegs("R1");
    checkTaps("R1");

    // R3 R4 R5: a single 1 walks through the 80-stage cascade
    shiftBit(1'b1);
    for (int i = 1; i < 80; i++) begin
      shiftBit(1'b0);
      if (i == 19 || i == 39 || i == 79) checkTaps("R4 R5");
    end
    chainM = '0; latchM = '0;
    for (int i = 0; i < 20; i++) shiftBit(i == 0);
    latchPulse();
    // R3: first bit entered sits at output 20
    check("R3", {78'd0, segA[39:38]}, 80'd0);
    checkSegs("R3");
    for (int i = 0; i < 20; i++) shiftBit(1'b0);
    latchPulse();
    // R3: after 40 edges the bit is at output 40
    check("R3", {78'd0, segA[79:78]}, 80'd0);
    checkSegs("R3");

    // R2: a rising edge followed by a steady high does not shift
    @(negedge clk); dataIn = 1'b1; shiftClk = 1'b1;
    repeat (4) @(negedge clk);
    latchPulse();
    checkSegs("R2");
    @(negedge clk); shiftClk = 1'b0;
    @(negedge clk); chainM = {chainM[78:0], 1'b1};
    latchPulse();
    checkSegs("R2");

    // R7: shifting with the latch clock low keeps the outputs
    for (int i = 0; i < 12; i++) shiftBit(i[0]);
    checkSegs("R7");
    checkTaps("R7");

    // R8 R9: toggling the alternating signal re-encodes the outputs
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); altFrame = ~altFrame;
      #1 checkSegs("R8 R9");
    end

    // R6: a shift edge and the latch clock in the same cycle
    @(negedge clk); dataIn = 1'b1; shiftClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0; latchClk = 1'b1;
    @(negedge clk); latchClk = 1'b0;
    latchM = chainM; chainM = {chainM[78:0], 1'b1};
    checkSegs("R6");
    checkTaps("R6");

    // random mix of shifts, latches and alternating toggles
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 6) shiftBit(1'($urandom_range(0, 1)));
      else if (sel < 8) begin latchPulse(); checkSegs("R6 R8"); end
      else begin @(negedge clk); altFrame = ~altFrame; #1 checkSegs("R9"); end
      if (n % 50 == 0) checkTaps("R5");
    end

    // R1: reset in mid-run clears everything
    @(negedge clk); rstN = 1'b0; altFrame = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chainM = '0; latchM = '0;
    @(negedge clk);
    checkSegs("R1");
    checkTaps("R1");

    finishRun();
  end

endmodule